// File: doc/BRIEF.md
# Early-Exit Vector Subtract Unit

This block walks a short vector held in a local element store and subtracts one scalar operand from each element, one element per clock. For every element it examines, it derives a 4-bit condition field from the signed 64-bit difference. The walk ends early at the first element whose difference meets a selectable exit test. The block then reports a shortened vector length, so that later operations only cover the elements that came before the exit point.

Software-side logic fills the element store through a load port and starts an operation. It gives the requested length, a length ceiling, the scalar, the exit test, a recording enable and a mode bit. The mode bit decides whether the exiting element is written back and counted. Results stream out on a write-back port and a condition port as they are produced. When the block is idle, the stored elements and condition fields can be read back through a synchronous read port.

Top module: `ffirst_vsub`

## Requirements
- R1: Each examined element that is written back is replaced, at its own index, by the element minus `scalar_in`, taken modulo 2^64; it also appears once on `wb_idx`/`wb_data` with `wb_vld` high.
- R2: A condition field is {bit3 = difference negative as a signed value, bit2 = difference positive, bit1 = difference zero, bit0 = 0}. Exactly one of bits 3..1 is set.
- R3: `tst_mode` selects the exit test: 2'b00 exits on a difference less than or equal to zero. 2'b01 exits on a zero difference. 2'b10 and 2'b11 exit on a zero difference and force condition recording.
- R4: Condition fields go out on `cf_vld`/`cf_idx`/`cf_data` and into the condition store only when `rec_en` is high or `tst_mode[1]` is set. Every accepted start marks all stored condition fields invalid (`rd_cf_vld` low).
- R5: With `vli` low, the exiting element is not written back, and `new_vl` equals its index.
- R6: With `vli` high, the exiting element is written back, and `new_vl` equals its index plus one.
- R7: The exiting element's condition field is still recorded. Elements after it are neither written back nor given a condition field.
- R8: If no examined element meets the exit test, all elements up to the effective length are processed and `new_vl` equals the effective length.
- R9: The effective length is the minimum of `vl_in`, `maxvl_in` and DEPTH. At completion `maxvl_out` equals the `maxvl_in` latched at start, and `src_step` and `dst_step` are zero.
- R10: One element is examined per clock. `done` is high for exactly one cycle, k+1 cycles after the start edge, where k is the number of elements examined.
- R11: A start whose effective length is zero raises `done` on the next cycle, writes nothing, records no condition and reports `new_vl` = 0.
- R12: A `start` while `busy` is ignored. An `ld_en` while `busy` or in a start cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write `ld_data` into the element store |
| ld_idx | input | AW | Element index for a load |
| ld_data | input | DW | Element value for a load |
| rd_idx | input | AW | Read-back index (idle only) |
| rd_data | output | DW | Element at `rd_idx`, one cycle later |
| rd_cf | output | 4 | Condition field at `rd_idx`, one cycle later |
| rd_cf_vld | output | 1 | Condition field at `rd_idx` was recorded by the last operation |
| start | input | 1 | Begin an operation |
| vl_in | input | LW | Requested vector length |
| maxvl_in | input | LW | Length ceiling |
| scalar_in | input | DW | Value subtracted from every element |
| tst_mode | input | 2 | Exit test select |
| rec_en | input | 1 | Record condition fields |
| vli | input | 1 | Write and count the exiting element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| new_vl | output | LW | Resulting vector length |
| maxvl_out | output | LW | Length ceiling of the last operation |
| src_step | output | AW | Source element step |
| dst_step | output | AW | Destination element step |
| wb_vld | output | 1 | Write-back event |
| wb_idx | output | AW | Write-back index |
| wb_data | output | DW | Write-back value |
| cf_vld | output | 1 | Condition event |
| cf_idx | output | AW | Condition index |
| cf_data | output | 4 | Condition field |

## Verification
The assertions assume that `start` is only meaningful when `busy` is low. They also assume that the read-back port is only consulted while idle, since the sequencer owns the store's read address during a run. The stimulus waits for `busy` to fall before every start and every read-back. The one exception is a run that deliberately issues a second start and a load while busy, to show that both are ignored. Vectors are reloaded in full before each operation, so exits at index 0, in the middle, at the last element, and never are all reached. The same holds for wrapped and negative differences and for clamped lengths.

// File: rtl/ffv_pkg.sv
package ffv_pkg;
  typedef enum logic [1:0] {
    TST_LE    = 2'b00,
    TST_EQ    = 2'b01,
    TST_AUTO  = 2'b10,
    TST_AUTO2 = 2'b11
  } tst_mode_e;

  localparam int CF_W   = 4;
  localparam int CF_NEG = 3;
  localparam int CF_POS = 2;
  localparam int CF_ZER = 1;
endpackage

// File: rtl/ffv_elem_ram.sv
module ffv_elem_ram #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ffv_cond_eval.sv
module ffv_cond_eval
  import ffv_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]   elem,
  input  logic [DW-1:0]   scalar,
  input  tst_mode_e       mode,
  output logic [DW-1:0]   diff,
  output logic [CF_W-1:0] cf,
  output logic            fail
);
  logic neg, zer, pos;

  always_comb begin
    diff = elem - scalar;
    neg  = diff[DW-1];
    zer  = (diff == '0);
    pos  = !neg && !zer;
    cf   = '0;
    cf[CF_NEG] = neg;
    cf[CF_POS] = pos;
    cf[CF_ZER] = zer;
    fail = (mode == TST_LE) ? (neg || zer) : zer;
  end
endmodule

// File: rtl/ffv_cf_store.sv
module ffv_cf_store
  import ffv_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CF_W-1:0] wcf,
  input  logic [AW-1:0]   raddr,
  output logic [CF_W-1:0] rcf,
  output logic            rvld
);
  logic [CF_W-1:0] fld [DEPTH];
  logic [DEPTH-1:0] vld;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        fld[g] <= '0;
        vld[g] <= 1'b0;
      end else if (clr) begin
        vld[g] <= 1'b0;
      end else if (we && (waddr == AW'(g))) begin
        fld[g] <= wcf;
        vld[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcf  <= '0;
      rvld <= 1'b0;
    end else begin
      rcf  <= fld[raddr];
      rvld <= vld[raddr];
    end
  end
endmodule

// File: rtl/ffv_seq_ctrl.sv
module ffv_seq_ctrl
  import ffv_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] vl_in,
  input  logic [LW-1:0] maxvl_in,
  input  logic [DW-1:0] scalar_in,
  input  logic [1:0]    tst_mode,
  input  logic          rec_en,
  input  logic          vli,
  input  logic          fail,
  output logic          accept,
  output logic          rd_own,
  output logic [AW-1:0] seq_raddr,
  output logic          seq_we,
  output logic          cf_en,
  output logic [AW-1:0] step_q,
  output logic [DW-1:0] scalar_q,
  output tst_mode_e     mode_q,
  output logic          busy_q,
  output logic          done_q,
  output logic [LW-1:0] new_vl_q,
  output logic [LW-1:0] maxvl_q
);
  logic [LW-1:0] vl_q, vl_min, vl_eff, step_ext;
  logic          vli_q, rec_q, last;

  always_comb begin
    vl_min    = (vl_in < maxvl_in) ? vl_in : maxvl_in;
    vl_eff    = (vl_min > LW'(DEPTH)) ? LW'(DEPTH) : vl_min;
    accept    = start && !busy_q;
    rd_own    = accept || busy_q;
    seq_raddr = accept ? '0 : step_q + AW'(1);
    step_ext  = LW'(step_q);
    last      = (step_ext + LW'(1) == vl_q);
    seq_we    = busy_q && (!fail || vli_q);
    cf_en     = busy_q && rec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      step_q   <= '0;
      vl_q     <= '0;
      new_vl_q <= '0;
      maxvl_q  <= '0;
      scalar_q <= '0;
      mode_q   <= TST_LE;
      vli_q    <= 1'b0;
      rec_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        vl_q     <= vl_eff;
        maxvl_q  <= maxvl_in;
        scalar_q <= scalar_in;
        mode_q   <= tst_mode_e'(tst_mode);
        vli_q    <= vli;
        rec_q    <= rec_en || tst_mode[1];
        step_q   <= '0;
        if (vl_eff == '0) begin
          done_q   <= 1'b1;
          new_vl_q <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (fail || last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          step_q   <= '0;
          new_vl_q <= !fail ? vl_q : (vli_q ? step_ext + LW'(1) : step_ext);
        end else begin
          step_q <= step_q + AW'(1);
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R9
  nvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (new_vl_q <= vl_q));
  // R9
  step_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (step_q == '0));
  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (step_ext < vl_q));
  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && vl_eff == '0) |=> (done_q && !busy_q && new_vl_q == '0));
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(scalar_q));
endmodule

// File: rtl/ffirst_vsub.sv
module ffirst_vsub
  import ffv_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_idx,
  input  logic [DW-1:0]   ld_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [CF_W-1:0] rd_cf,
  output logic            rd_cf_vld,
  input  logic            start,
  input  logic [LW-1:0]   vl_in,
  input  logic [LW-1:0]   maxvl_in,
  input  logic [DW-1:0]   scalar_in,
  input  logic [1:0]      tst_mode,
  input  logic            rec_en,
  input  logic            vli,
  output logic            busy,
  output logic            done,
  output logic [LW-1:0]   new_vl,
  output logic [LW-1:0]   maxvl_out,
  output logic [AW-1:0]   src_step,
  output logic [AW-1:0]   dst_step,
  output logic            wb_vld,
  output logic [AW-1:0]   wb_idx,
  output logic [DW-1:0]   wb_data,
  output logic            cf_vld,
  output logic [AW-1:0]   cf_idx,
  output logic [CF_W-1:0] cf_data
);
  logic            accept, rd_own, seq_we, cf_en, fail;
  logic [AW-1:0]   seq_raddr, step_q, ram_raddr, ram_waddr;
  logic [DW-1:0]   scalar_q, diff, ram_q, ram_wdata;
  logic [CF_W-1:0] cf;
  tst_mode_e       mode_q;
  logic            ld_ok, ram_we;

  ffv_seq_ctrl #(.DW(DW), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .maxvl_in(maxvl_in),
    .scalar_in(scalar_in), .tst_mode(tst_mode), .rec_en(rec_en), .vli(vli),
    .fail(fail), .accept(accept), .rd_own(rd_own), .seq_raddr(seq_raddr),
    .seq_we(seq_we), .cf_en(cf_en), .step_q(step_q), .scalar_q(scalar_q),
    .mode_q(mode_q), .busy_q(busy), .done_q(done), .new_vl_q(new_vl),
    .maxvl_q(maxvl_out)
  );

  always_comb begin
    ld_ok     = ld_en && !busy && !start;
    ram_we    = seq_we || ld_ok;
    ram_waddr = seq_we ? step_q : ld_idx;
    ram_wdata = seq_we ? diff : ld_data;
    ram_raddr = rd_own ? seq_raddr : rd_idx;
  end

  ffv_elem_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  ffv_cond_eval #(.DW(DW)) eval_i (
    .elem(ram_q), .scalar(scalar_q), .mode(mode_q),
    .diff(diff), .cf(cf), .fail(fail)
  );

  ffv_cf_store #(.DEPTH(DEPTH)) cfs_i (
    .clk(clk), .rst(rst), .clr(accept), .we(cf_en), .waddr(step_q),
    .wcf(cf), .raddr(rd_idx), .rcf(rd_cf), .rvld(rd_cf_vld)
  );

  assign rd_data  = ram_q;
  assign src_step = step_q;
  assign dst_step = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld  <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      cf_vld  <= 1'b0;
      cf_idx  <= '0;
      cf_data <= '0;
    end else begin
      wb_vld  <= seq_we;
      wb_idx  <= step_q;
      wb_data <= diff;
      cf_vld  <= cf_en;
      cf_idx  <= step_q;
      cf_data <= cf;
    end
  end

  // R2
  cf_shape_chk: assert property (@(posedge clk) disable iff (rst)
    cf_vld |-> ($onehot(cf_data[3:1]) && !cf_data[0]));
  // R7
  wb_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_vld || cf_vld) |-> ($past(busy)));
  // R11
  no_event_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |=> !wb_vld);
endmodule

// File: tb/ffirst_vsub_tb_top.sv
module ffirst_vsub_tb_top;
  localparam int DW = 64, DEPTH = 8, AW = 3, LW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_en = 0, start = 0, rec_en = 0, vli = 0;
  logic [AW-1:0] ld_idx = '0, rd_idx = '0;
  logic [DW-1:0] ld_data = '0, scalar_in = '0;
  logic [LW-1:0] vl_in = '0, maxvl_in = '0;
  logic [1:0] tst_mode = '0;
  logic [DW-1:0] rd_data, wb_data;
  logic [3:0] rd_cf, cf_data;
  logic rd_cf_vld, busy, done, wb_vld, cf_vld;
  logic [LW-1:0] new_vl, maxvl_out;
  logic [AW-1:0] src_step, dst_step, wb_idx, cf_idx;

  always #10 clk = ~clk;

  ffirst_vsub #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_cf(rd_cf), .rd_cf_vld(rd_cf_vld),
    .start(start), .vl_in(vl_in), .maxvl_in(maxvl_in), .scalar_in(scalar_in),
    .tst_mode(tst_mode), .rec_en(rec_en), .vli(vli), .busy(busy), .done(done),
    .new_vl(new_vl), .maxvl_out(maxvl_out), .src_step(src_step),
    .dst_step(dst_step), .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data),
    .cf_vld(cf_vld), .cf_idx(cf_idx), .cf_data(cf_data)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [3:0]    cfs [DEPTH];
  logic          cfv [DEPTH];
  logic [AW+DW-1:0] exp_wb [$];
  logic [AW+3:0]    exp_cf [$];

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected events as the design emits them
  always @(negedge clk) begin
    if (!rst && wb_vld) begin
      if (exp_wb.size() == 0) chk("R7", "unexpected write-back idx", {61'd0, wb_idx}, 64'hffff);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_wb.pop_front();
        chk("R5", "write-back index", {61'd0, wb_idx}, {61'd0, e[AW+DW-1:DW]});
        chk("R1", "write-back data", wb_data, e[DW-1:0]);
      end
    end
    if (!rst && cf_vld) begin
      if (exp_cf.size() == 0) chk("R4", "unexpected condition idx", {61'd0, cf_idx}, 64'hffff);
      else begin
        logic [AW+3:0] c;
        c = exp_cf.pop_front();
        chk("R7", "condition index", {61'd0, cf_idx}, {61'd0, c[AW+3:4]});
        chk("R2", "condition field", {60'd0, cf_data}, {60'd0, c[3:0]});
      end
    end
  end

  task automatic load_all();
    for (int i = 0; i < DEPTH; i++) begin
      ld_en = 1; ld_idx = AW'(i); ld_data = mem[i];
      @(negedge clk);
    end
    ld_en = 0;
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = AW'(i);
      @(negedge clk);
      chk("R7", {tag, " stored element"}, rd_data, mem[i]);
      chk("R4", {tag, " condition valid"}, {63'd0, rd_cf_vld}, {63'd0, cfv[i]});
      if (cfv[i]) chk("R2", {tag, " stored condition"}, {60'd0, rd_cf}, {60'd0, cfs[i]});
    end
  endtask

  task automatic run_op(input string tag, input logic [DW-1:0] sc,
                        input int vlr, input int mxr, input logic [1:0] md,
                        input logic rc, input logic vi, input bit poke);
    int vle, proc, nvl, lat;
    bit rec;
    vle = (vlr < mxr) ? vlr : mxr;
    if (vle > DEPTH) vle = DEPTH;
    rec = rc || md[1];
    proc = vle; nvl = vle;
    for (int i = 0; i < DEPTH; i++) cfv[i] = 0;
    for (int i = 0; i < vle; i++) begin
      logic [DW-1:0] d;
      logic ng, z, f;
      logic [3:0] c;
      d = mem[i] - sc; ng = d[DW-1]; z = (d == 0);
      c = {ng, !ng && !z, z, 1'b0};
      f = (md == 2'b00) ? (ng || z) : z;
      if (rec) begin exp_cf.push_back({AW'(i), c}); cfs[i] = c; cfv[i] = 1; end
      if (!f || vi) begin exp_wb.push_back({AW'(i), d}); mem[i] = d; end
      if (f) begin proc = i + 1; nvl = vi ? i + 1 : i; break; end
    end
    while (busy) @(negedge clk);
    scalar_in = sc; vl_in = LW'(vlr); maxvl_in = LW'(mxr);
    tst_mode = md; rec_en = rc; vli = vi; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 100) begin
      if (poke && lat == 2) begin
        start = 1; vl_in = 1; scalar_in = 64'd77;
        ld_en = 1; ld_idx = 3'd7; ld_data = 64'd999;
      end else begin
        start = 0; ld_en = 0;
      end
      @(negedge clk);
      lat++;
    end
    start = 0; ld_en = 0;
    chk("R10", {tag, " done latency"}, lat, proc + 1);
    chk("R8", {tag, " new length"}, {60'd0, new_vl}, nvl);
    chk("R9", {tag, " ceiling kept"}, {60'd0, maxvl_out}, mxr);
    chk("R9", {tag, " steps cleared"}, {58'd0, src_step, dst_step}, 0);
    @(negedge clk);
    chk("R10", {tag, " done one cycle"}, {63'd0, done}, 0);
    chk("R1", {tag, " pending write-backs"}, exp_wb.size(), 0);
    chk("R4", {tag, " pending conditions"}, exp_cf.size(), 0);
    exp_wb.delete(); exp_cf.delete();
    readback(tag);
  endtask

  task automatic set_vec(input logic [DW-1:0] a, b, c, d, e, f, g, h);
    mem[0] = a; mem[1] = b; mem[2] = c; mem[3] = d;
    mem[4] = e; mem[5] = f; mem[6] = g; mem[7] = h;
    load_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10", "reset busy", {63'd0, busy}, 0);
    chk("R10", "reset done", {63'd0, done}, 0);
    chk("R8", "reset new length", {60'd0, new_vl}, 0);
    chk("R1", "reset write-back", {62'd0, wb_vld, cf_vld}, 0);

    // R3 zero test, R5 element not written
    set_vec(9, 8, 3, 4, 1, 1, 1, 1);
    run_op("eq_vli0", 3, 4, 4, 2'b01, 1, 0, 0);
    // R6 zero test, exiting element written and counted
    set_vec(9, 8, 3, 4, 1, 1, 1, 1);
    run_op("eq_vli1", 3, 4, 4, 2'b01, 1, 1, 0);
    // R3 less-or-equal test
    set_vec(9, 8, 3, 4, 1, 1, 1, 1);
    run_op("le_vli0", 3, 4, 4, 2'b00, 1, 0, 0);
    // R3 R4 shorthand mode forces recording
    set_vec(9, 8, 3, 4, 1, 1, 1, 1);
    run_op("auto_norec", 3, 4, 4, 2'b10, 0, 0, 0);
    // R4 no recording
    set_vec(9, 8, 3, 4, 1, 1, 1, 1);
    run_op("eq_norec", 3, 4, 4, 2'b01, 0, 1, 0);
    // R8 no exit
    set_vec(10, 20, 30, 40, 50, 60, 70, 80);
    run_op("noexit", 1, 5, 8, 2'b00, 1, 0, 0);
    // R5 R6 exit at index 0
    set_vec(5, 9, 9, 9, 9, 9, 9, 9);
    run_op("first_vli0", 5, 8, 8, 2'b00, 1, 0, 0);
    set_vec(5, 9, 9, 9, 9, 9, 9, 9);
    run_op("first_vli1", 5, 8, 8, 2'b00, 1, 1, 0);
    // R2 signed: 0-1 negative, and a wrapped large value
    set_vec(64'h8000_0000_0000_0000, 0, 2, 2, 2, 2, 2, 2);
    run_op("signed", 1, 8, 8, 2'b00, 1, 0, 0);
    // R9 length clamps
    set_vec(9, 9, 9, 9, 9, 9, 9, 9);
    run_op("clamp_max", 1, 7, 3, 2'b00, 1, 0, 0);
    set_vec(9, 9, 9, 9, 9, 9, 9, 2);
    run_op("clamp_depth", 2, 15, 15, 2'b01, 1, 1, 0);
    // R11 zero length
    set_vec(3, 3, 3, 3, 3, 3, 3, 3);
    run_op("zero_len", 3, 0, 8, 2'b01, 1, 1, 0);
    // R12 start and load while busy
    set_vec(9, 9, 9, 9, 9, 9, 9, 9);
    run_op("busy_poke", 2, 8, 8, 2'b00, 1, 0, 1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule